// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block keeps the interrupt state of a serial port. Single-cycle event pulses set sticky raw status bits. These sources are the receive errors, receive timeout, end of transmission, modem clear-to-send change, the DMA completions and the LIN events. A mask register selects which raw bits reach the masked status vector and the single combined interrupt line. Software clears raw bits by writing ones to a clear strobe. Two further bits come from comparing the transmit and receive FIFO occupancy against programmable trigger levels. A direct holding-register mode applies when the FIFOs are switched off.

The unit also sits in the receive DMA request path. When the stop-DMA-on-error option is on, any pending receive error blocks the request. The FIFOs, the serial engines and the bus decode live elsewhere and feed this block through counts, pulses and write strobes.

Status bit layout, which every vector port shares:

| Bit | Source |
|---|---|
| 0 | TX level |
| 1 | RX level |
| 2 | receive timeout |
| 3 | framing error |
| 4 | parity error |
| 5 | break error |
| 6 | overrun |
| 7 | end of transmission |
| 8 | CTS change |
| 9 | TX DMA done |
| 10 | RX DMA done |
| 11 | LIN break detected |
| 12 | LIN break timeout |
| 13 | LIN sync timeout |

Top module: `uart_irq_ctrl`

## Requirements
- R1: `masked_o` equals `raw_o & mask_o` bit for bit. `irq_o` is high exactly when any bit of `masked_o` is high. A mask write takes effect one cycle after its strobe.
- R2: A cycle with `clr_we_i` high clears each raw bit whose `clr_wdata_i` bit is 1, from the next cycle on. Zero bits of `clr_wdata_i`, and any `clr_wdata_i` while `clr_we_i` is low, leave the raw bits unchanged.
- R3: A one-cycle pulse on an event bit of `ev_i` (bits 2 to 13) sets that raw bit in the next cycle. The bit stays set until it is cleared. If the pulse and a clear of the same bit land in the same cycle, the bit ends up set.
- R4: Raw bit 2 (receive timeout) is set only if mask bit 2 is 1 in the following cycle. Writing mask bit 2 to 0 also drops raw bit 2, so that raw bit and masked bit always agree.
- R5: With `fifo_en_i` = 1, raw bit 0 is 1 one cycle after `tx_count_i` <= TX threshold. A clear holds it at 0 until the condition has gone false and then true again.
- R6: With `fifo_en_i` = 1, raw bit 1 is 1 one cycle after `rx_count_i` >= RX threshold. It falls when the count drops below the threshold. A clear holds it at 0 until the condition has gone false and then true again.
- R7: Trigger select codes 0, 1, 2, 3 and 4 give thresholds of FIFO_DEPTH times 1/8, 2/8, 4/8, 6/8 and 7/8. Codes 5 to 7 act as code 2. Both selects load on `lvl_we_i` and reset to 2.
- R8: With `fifo_en_i` = 0, the TX level condition is `tx_count_i` == 0 and the RX level condition is `rx_count_i` != 0.
- R9: With the stop-on-error option on (`doe_i` loaded via `doe_we_i`) and any of raw bits 3 to 6 set, `rx_dma_req_o` is 0. Otherwise it follows `rx_dma_req_i`.
- R10: While `rst` is high, raw bits, mask and option read 0. After release, only the level bits may rise, per R5 to R8.
- R11: Pulses on `ev_i` bits 0 and 1 have no effect. The level bits follow only the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ev_i | input | 14 | event pulses, layout above |
| fifo_en_i | input | 1 | FIFO mode (1) or holding-register mode (0) |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| mask_we_i | input | 1 | mask write strobe |
| mask_wdata_i | input | 14 | new mask value |
| clr_we_i | input | 1 | clear write strobe |
| clr_wdata_i | input | 14 | write-1-to-clear pattern |
| lvl_we_i | input | 1 | trigger select write strobe |
| tx_sel_i | input | 3 | TX trigger select code |
| rx_sel_i | input | 3 | RX trigger select code |
| doe_we_i | input | 1 | stop-on-error option write strobe |
| doe_i | input | 1 | stop-on-error option value |
| rx_dma_req_i | input | 1 | receive DMA request from the FIFO side |
| raw_o | output | 14 | raw status |
| mask_o | output | 14 | mask register |
| masked_o | output | 14 | masked status |
| irq_o | output | 1 | combined interrupt |
| rx_dma_req_o | output | 1 | gated receive DMA request |

## Verification
The bench builds the block with FIFO_DEPTH = 8, which makes the thresholds the small integers 1, 2, 4, 6 and 7. With that depth, every select code, including the reserved ones, can be swept against every occupancy from 0 to 8, in both FIFO and holding-register mode, for both directions. Each event bit is then driven on its own, through set, mask and clear. Separate cases cover the timeout gating, a pulse colliding with a clear, clear-after-level re-arming, and the DMA gate.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IRQ_W     = 14;
  localparam int B_TXLVL   = 0;
  localparam int B_RXLVL   = 1;
  localparam int B_RXTMO   = 2;
  localparam int B_FRAME   = 3;
  localparam int B_PARITY  = 4;
  localparam int B_BREAK   = 5;
  localparam int B_OVERRUN = 6;

  localparam logic [IRQ_W-1:0] LVL_BITS = 14'h0003;
  localparam logic [IRQ_W-1:0] EV_BITS  = ~LVL_BITS;
  localparam logic [IRQ_W-1:0] ERR_BITS = 14'h0078;
  localparam logic [IRQ_W-1:0] TMO_BIT  = 14'h0004;
  localparam logic [2:0]       SEL_RST  = 3'd2;

  // Trigger select code to threshold in eighths of the FIFO depth
  function automatic logic [2:0] trig_eighths(input logic [2:0] sel);
    case (sel)
      3'd0:    trig_eighths = 3'd1;
      3'd1:    trig_eighths = 3'd2;
      3'd3:    trig_eighths = 3'd6;
      3'd4:    trig_eighths = 3'd7;
      default: trig_eighths = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_thresh.sv
module uart_irq_thresh
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter bit IS_TX = 1'b1
) (
  input  logic             fifo_en_i,
  input  logic [2:0]       sel_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             cond_o
);
  localparam int PW = CNT_W + 3;

  logic [PW-1:0]    prod;
  logic [CNT_W-1:0] thr;

  always_comb begin
    prod = PW'(DEPTH) * PW'(trig_eighths(sel_i));
    thr  = CNT_W'(prod >> 3);
  end

  generate
    if (IS_TX) begin : g_tx
      assign cond_o = fifo_en_i ? (count_i <= thr) : (count_i == '0);
    end else begin : g_rx
      assign cond_o = fifo_en_i ? (count_i >= thr) : (count_i != '0);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] keep_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] gate_i,
  output logic [W-1:0] raw_o
);
  logic [W-1:0] raw_q;

  // Per bit: hold unless cleared or its condition drops; a set beats a clear
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) raw_q[i] <= 1'b0;
        else     raw_q[i] <= ((raw_q[i] & keep_i[i] & ~clr_i[i]) | set_i[i]) & gate_i[i];
      end
    end
  endgenerate

  assign raw_o = raw_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] ev_i,
  input  logic             fifo_en_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             mask_we_i,
  input  logic [IRQ_W-1:0] mask_wdata_i,
  input  logic             clr_we_i,
  input  logic [IRQ_W-1:0] clr_wdata_i,
  input  logic             lvl_we_i,
  input  logic [2:0]       tx_sel_i,
  input  logic [2:0]       rx_sel_i,
  input  logic             doe_we_i,
  input  logic             doe_i,
  input  logic             rx_dma_req_i,
  output logic [IRQ_W-1:0] raw_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] masked_o,
  output logic             irq_o,
  output logic             rx_dma_req_o
);
  logic [IRQ_W-1:0] mask_q, mask_n;
  logic [2:0]       tx_sel_q, rx_sel_q;
  logic             doe_q;
  logic             tx_cond, rx_cond;
  logic [1:0]       cond_q;
  logic [IRQ_W-1:0] set_v, keep_v, clr_v, gate_v;

  assign mask_n = mask_we_i ? mask_wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      tx_sel_q <= SEL_RST;
      rx_sel_q <= SEL_RST;
      doe_q    <= 1'b0;
      cond_q   <= 2'b00;
    end else begin
      mask_q <= mask_n;
      if (lvl_we_i) begin
        tx_sel_q <= tx_sel_i;
        rx_sel_q <= rx_sel_i;
      end
      if (doe_we_i) doe_q <= doe_i;
      cond_q <= {rx_cond, tx_cond};
    end
  end

  uart_irq_thresh #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_thr (
    .fifo_en_i(fifo_en_i), .sel_i(tx_sel_q), .count_i(tx_count_i), .cond_o(tx_cond)
  );

  uart_irq_thresh #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_thr (
    .fifo_en_i(fifo_en_i), .sel_i(rx_sel_q), .count_i(rx_count_i), .cond_o(rx_cond)
  );

  always_comb begin
    set_v            = ev_i & EV_BITS;
    set_v[B_TXLVL]   = tx_cond & ~cond_q[0];
    set_v[B_RXLVL]   = rx_cond & ~cond_q[1];
    keep_v           = '1;
    keep_v[B_TXLVL]  = tx_cond;
    keep_v[B_RXLVL]  = rx_cond;
    gate_v           = '1;
    gate_v[B_RXTMO]  = mask_n[B_RXTMO];
    clr_v            = clr_we_i ? clr_wdata_i : '0;
  end

  uart_irq_status #(.W(IRQ_W)) u_status (
    .clk(clk), .rst(rst), .set_i(set_v), .keep_i(keep_v),
    .clr_i(clr_v), .gate_i(gate_v), .raw_o(raw_o)
  );

  assign mask_o       = mask_q;
  assign masked_o     = raw_o & mask_q;
  assign irq_o        = |masked_o;
  assign rx_dma_req_o = rx_dma_req_i & ~(doe_q & |(raw_o & ERR_BITS));
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
  import uart_irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [IRQ_W-1:0] ev_i,
  input logic             clr_we_i,
  input logic [IRQ_W-1:0] clr_wdata_i,
  input logic [IRQ_W-1:0] raw_o,
  input logic [IRQ_W-1:0] mask_o,
  input logic             irq_o,
  input logic             rx_dma_req_o,
  input logic             doe_q
);
  localparam logic [IRQ_W-1:0] PLAIN_EV = EV_BITS & ~TMO_BIT;

  a_r1_no_mask_no_irq: assert property (@(posedge clk) disable iff (rst)
    (mask_o == '0) |-> !irq_o);

  a_r2_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_we_i && ((clr_wdata_i & ~ev_i & EV_BITS) != '0))
    |=> ((raw_o & $past(clr_wdata_i & ~ev_i & EV_BITS)) == '0));

  a_r3_event_sets: assert property (@(posedge clk) disable iff (rst)
    ((ev_i & PLAIN_EV) != '0)
    |=> ((raw_o & $past(ev_i & PLAIN_EV)) == $past(ev_i & PLAIN_EV)));

  a_r4_tmo_follows_mask: assert property (@(posedge clk) disable iff (rst)
    raw_o[B_RXTMO] |-> mask_o[B_RXTMO]);

  a_r9_dma_blocked: assert property (@(posedge clk) disable iff (rst)
    (doe_q && ((raw_o & ERR_BITS) != '0)) |-> !rx_dma_req_o);
endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (
  .clk(clk), .rst(rst), .ev_i(ev_i), .clr_we_i(clr_we_i), .clr_wdata_i(clr_wdata_i),
  .raw_o(raw_o), .mask_o(mask_o), .irq_o(irq_o), .rx_dma_req_o(rx_dma_req_o), .doe_q(doe_q)
);

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;
  localparam int DEPTH = 8;
  localparam int CW    = 4;
  localparam int W     = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  ev = '0;
  logic          fifo_en = 1'b1;
  logic [CW-1:0] tx_cnt = '0, rx_cnt = '0;
  logic          mask_we = 1'b0, clr_we = 1'b0, lvl_we = 1'b0, doe_we = 1'b0, doe = 1'b0;
  logic [W-1:0]  mask_wd = '0, clr_wd = '0;
  logic [2:0]    tx_sel = 3'd2, rx_sel = 3'd2;
  logic          dreq = 1'b0;
  logic [W-1:0]  raw, mask, masked;
  logic          irq, dreq_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .ev_i(ev), .fifo_en_i(fifo_en),
    .tx_count_i(tx_cnt), .rx_count_i(rx_cnt),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .clr_we_i(clr_we), .clr_wdata_i(clr_wd),
    .lvl_we_i(lvl_we), .tx_sel_i(tx_sel), .rx_sel_i(rx_sel),
    .doe_we_i(doe_we), .doe_i(doe), .rx_dma_req_i(dreq),
    .raw_o(raw), .mask_o(mask), .masked_o(masked), .irq_o(irq), .rx_dma_req_o(dreq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int thr_of(input int sel);
    int e;
    case (sel)
      0: e = 1; 1: e = 2; 3: e = 6; 4: e = 7;
      default: e = 4;
    endcase
    return (DEPTH * e) / 8;
  endfunction

  task automatic pulse(input logic [W-1:0] v);
    ev = v; cyc(1); ev = '0;
  endtask

  task automatic clear(input logic [W-1:0] v);
    clr_we = 1'b1; clr_wd = v; cyc(1); clr_we = 1'b0; clr_wd = '0;
  endtask

  task automatic set_mask(input logic [W-1:0] v);
    mask_we = 1'b1; mask_wd = v; cyc(1); mask_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10 raw in reset", 32'(raw), 0);
    chk("R10 mask in reset", 32'(mask), 0);
    chk("R10 irq in reset", 32'(irq), 0);
    rst = 1'b0;
    tx_cnt = 4'd4;
    cyc(2);
    // R7 reset select is 2 -> threshold 4
    chk("R7 reset tx sel, count 4", 32'(raw[0]), 1);
    chk("R10 event bits after reset", 32'(raw[13:2]), 0);
    tx_cnt = 4'd5; cyc(2);
    chk("R7 reset tx sel, count 5", 32'(raw[0]), 0);

    // R5 R6 R7 R8 sweep over select codes, modes, counts
    for (int s = 0; s < 8; s++) begin
      for (int fe = 0; fe < 2; fe++) begin
        for (int c = 0; c <= DEPTH; c++) begin
          int t;
          logic etx, erx;
          lvl_we = 1'b1; tx_sel = 3'(s); rx_sel = 3'(s);
          fifo_en = fe[0]; tx_cnt = CW'(c); rx_cnt = CW'(c);
          cyc(1); lvl_we = 1'b0; cyc(1);
          t = thr_of(s);
          etx = fe[0] ? (c <= t) : (c == 0);
          erx = fe[0] ? (c >= t) : (c != 0);
          if (fe[0]) begin
            chk($sformatf("R5 R7 tx sel=%0d cnt=%0d", s, c), 32'(raw[0]), 32'(etx));
            chk($sformatf("R6 R7 rx sel=%0d cnt=%0d", s, c), 32'(raw[1]), 32'(erx));
          end else begin
            chk($sformatf("R8 tx cnt=%0d", c), 32'(raw[0]), 32'(etx));
            chk($sformatf("R8 rx cnt=%0d", c), 32'(raw[1]), 32'(erx));
          end
        end
      end
    end

    // R5 clear holds low until condition re-arms
    lvl_we = 1'b1; tx_sel = 3'd2; rx_sel = 3'd2; fifo_en = 1'b1;
    tx_cnt = 4'd0; rx_cnt = 4'd8; cyc(1); lvl_we = 1'b0; cyc(2);
    chk("R5 tx level before clear", 32'(raw[0]), 1);
    chk("R6 rx level before clear", 32'(raw[1]), 1);
    clear(14'h0003);
    chk("R5 tx cleared", 32'(raw[0]), 0);
    chk("R6 rx cleared", 32'(raw[1]), 0);
    cyc(3);
    chk("R5 tx stays cleared", 32'(raw[0]), 0);
    chk("R6 rx stays cleared", 32'(raw[1]), 0);
    tx_cnt = 4'd6; rx_cnt = 4'd1; cyc(2);
    tx_cnt = 4'd0; rx_cnt = 4'd8; cyc(2);
    chk("R5 tx re-armed", 32'(raw[0]), 1);
    chk("R6 rx re-armed", 32'(raw[1]), 1);
    rx_cnt = 4'd3; cyc(2);
    chk("R6 rx falls below level", 32'(raw[1]), 0);

    // park levels false
    tx_cnt = 4'd8; rx_cnt = 4'd0; cyc(2);
    // R11 level positions of ev ignored
    pulse(14'h0003); cyc(1);
    chk("R11 ev level bits ignored", 32'(raw[1:0]), 0);

    // R3 R1 R2 each plain event bit
    set_mask(14'h3FFC);
    for (int b = 3; b < W; b++) begin
      pulse(W'(1) << b);
      chk($sformatf("R3 set bit %0d", b), 32'(raw), 32'(1) << b);
      chk($sformatf("R1 masked bit %0d", b), 32'(masked), 32'(1) << b);
      chk($sformatf("R1 irq bit %0d", b), 32'(irq), 1);
      cyc(2);
      chk($sformatf("R3 sticky bit %0d", b), 32'(raw[b]), 1);
      clear(W'(1) << b);
      chk($sformatf("R2 clear bit %0d", b), 32'(raw), 0);
      chk($sformatf("R1 irq dropped bit %0d", b), 32'(irq), 0);
    end

    // R1 mask off blocks irq
    set_mask(14'h0000);
    pulse(14'h0100);
    chk("R1 raw set with mask 0", 32'(raw[8]), 1);
    chk("R1 masked zero", 32'(masked), 0);
    chk("R1 irq off with mask 0", 32'(irq), 0);
    // R2 zero data and no strobe
    clr_we = 1'b1; clr_wd = '0; cyc(1); clr_we = 1'b0;
    chk("R2 zero clear no effect", 32'(raw[8]), 1);
    clr_wd = 14'h3FFF; cyc(1); clr_wd = '0;
    chk("R2 no strobe no effect", 32'(raw[8]), 1);
    // R3 pulse and clear same cycle
    ev = 14'h0080; clr_we = 1'b1; clr_wd = 14'h0180; cyc(1);
    ev = '0; clr_we = 1'b0; clr_wd = '0;
    chk("R3 event wins over clear", 32'(raw[7]), 1);
    chk("R2 other bit cleared", 32'(raw[8]), 0);
    clear(14'h0080);

    // R4 timeout gating
    pulse(14'h0004);
    chk("R4 timeout blocked by mask", 32'(raw[2]), 0);
    set_mask(14'h0004);
    pulse(14'h0004);
    chk("R4 timeout set with mask", 32'(raw[2]), 1);
    chk("R4 timeout masked equal", 32'(masked[2]), 1);
    set_mask(14'h0000);
    chk("R4 mask off drops timeout", 32'(raw[2]), 0);

    // R9 DMA gate
    dreq = 1'b1; doe_we = 1'b1; doe = 1'b1; cyc(1); doe_we = 1'b0;
    chk("R9 request passes no error", 32'(dreq_o), 1);
    pulse(14'h0010);
    chk("R9 request blocked on parity", 32'(dreq_o), 0);
    clear(14'h0010);
    chk("R9 request restored", 32'(dreq_o), 1);
    pulse(14'h0040);
    chk("R9 request blocked on overrun", 32'(dreq_o), 0);
    doe_we = 1'b1; doe = 1'b0; cyc(1); doe_we = 1'b0;
    chk("R9 option off passes", 32'(dreq_o), 1);
    pulse(14'h0200);
    doe_we = 1'b1; doe = 1'b1; clr_we = 1'b1; clr_wd = 14'h0040; cyc(1);
    doe_we = 1'b0; clr_we = 1'b0; clr_wd = '0;
    chk("R9 non-error bit passes", 32'(dreq_o), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule